// File: doc/BRIEF.md
# 32-to-16-bit bus cycle translator

This block lets a 32-bit processor with dynamic bus sizing drive an older 16-bit asynchronous system bus. Each processor request (address, transfer size, direction) becomes one 16-bit legacy cycle. The block drives the legacy address strobe, the upper and lower data strobes, read/write and the word address. It waits for the legacy data acknowledge and then answers the processor with a size acknowledge that marks a 16-bit port. When the processor sees that answer it runs the rest of a wider transfer as further cycles. A bus-error input ends a cycle at once.

The processor clock may be equal to, 1.5 times or twice the legacy bus clock. A configuration input selects the ratio. An internal tick generator marks the processor-clock edges that line up with legacy clock edges, and all legacy timing steps on those ticks. The processor's 3-clock cycle is stretched to the legacy 4-clock cycle by one extra state before the strobes. The legacy acknowledge and bus-error inputs are asynchronous and pass through two-flop synchronisers.

The state machine has seven states. IDLE goes to STRETCH on a request and latches address, size and direction. STRETCH goes to ADDR on a tick. ADDR goes to STRB on a tick, and AS is asserted. STRB goes to WAIT on a tick, and the data strobes are asserted from here on for writes. WAIT goes to BERR at once when bus error is seen. WAIT goes to ACK on a tick when acknowledge is seen. ACK and BERR go back to IDLE when the processor drops its request.

Top module: `bus_size_bridge`

## Requirements
- R1: After reset the legacy strobes leg_as_n, leg_uds_n and leg_lds_n are high, leg_rw is high, cpu_dsack_n is 2'b11 and cpu_berr is 0.
- R2: With ratio 1:1, leg_as_n goes low on the third rising clock edge after cpu_req is first sampled high. This is one clock more than the processor's own cycle. At ratio 1.5x it goes low after 3 to 5 clocks, and at 2x after 4 or 5 clocks.
- R3: cpu_siz encodes 01 as byte, 10 as word, 11 as three bytes and 00 as long. If cpu_addr[0] is 1, only leg_lds_n is asserted. If cpu_addr[0] is 0 and the size is byte, only leg_uds_n is asserted. Any other size at an even address asserts both.
- R4: leg_rw is 1 for a read (cpu_rd=1) and 0 for a write. On a read the data strobes are asserted together with leg_as_n. On a write they are asserted one legacy tick later.
- R5: A completed cycle returns cpu_dsack_n = 2'b01, with bit 1 low and bit 0 high (16-bit port). The value is held while cpu_req stays high, and cpu_dsack_n goes back to 2'b11 one clock after cpu_req drops. A long transfer therefore takes two legacy cycles.
- R6: cpu_dsack_n is asserted only after leg_dtack_n low has passed two synchroniser flops, at least 3 clocks after it went low. While leg_dtack_n stays high the cycle waits with leg_as_n low.
- R7: A leg_dtack_n that is already low never ends the cycle early. The acknowledge comes exactly two legacy ticks after leg_as_n is asserted.
- R8: ratio_sel 0 selects a tick every clock, 1 selects two ticks in every three clocks, and 2 or 3 selects a tick every second clock. With early acknowledge, the time from AS to acknowledge is therefore 2, 3 or 4 clocks.
- R9: leg_berr_n low while the cycle waits sets cpu_berr without waiting for a tick. It also negates all legacy strobes and keeps cpu_dsack_n at 2'b11. cpu_berr is held until cpu_req drops, and then the block is idle.
- R10: The data strobes are never asserted while leg_as_n is high. leg_as_n stays high for at least one legacy tick between cycles.
- R11: During a cycle leg_addr equals cpu_addr[AW-1:1] of the request and stays stable while leg_as_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| ratio_sel | input | 2 | Clock ratio: 0 1:1, 1 1.5x, 2/3 2x |
| cpu_req | input | 1 | Processor cycle request, held until answered |
| cpu_addr | input | AW | Processor byte address |
| cpu_siz | input | 2 | Processor transfer size |
| cpu_rd | input | 1 | 1 read, 0 write |
| cpu_dsack_n | output | 2 | Size acknowledge, active low |
| cpu_berr | output | 1 | Bus-error response to processor |
| leg_addr | output | AW-1 | Legacy word address |
| leg_as_n | output | 1 | Legacy address strobe |
| leg_uds_n | output | 1 | Legacy upper data strobe |
| leg_lds_n | output | 1 | Legacy lower data strobe |
| leg_rw | output | 1 | Legacy read/write |
| leg_dtack_n | input | 1 | Legacy data acknowledge, asynchronous |
| leg_berr_n | input | 1 | Legacy bus error, asynchronous |

## Verification
The bench holds the legacy acknowledge low before a cycle starts, at every ratio. A design that sampled it without the stretch or tick gating would answer in fewer than two ticks and return stale data. It also holds the acknowledge off for many clocks, and measures the delay from a late acknowledge to the size answer. A bridge that skipped a synchroniser stage or ignored the acknowledge would answer too soon. Odd addresses with word and long sizes are exercised, where a naive decoder would assert both strobes. The bench also checks the write strobe lag, a long transfer split into two cycles, and a bus error that must negate the strobes and never raise the size acknowledge.

// File: rtl/bsb_pkg.sv
`timescale 1ns/1ps
package bsb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRETCH,
        ST_ADDR,
        ST_STRB,
        ST_WAIT,
        ST_ACK,
        ST_BERR
    } bsb_state_e;

    localparam logic [1:0] SIZ_BYTE  = 2'b01;
    localparam logic [1:0] RATIO_1X  = 2'b00;
    localparam logic [1:0] RATIO_3_2 = 2'b01;
    localparam logic [1:0] ACK_PORT16 = 2'b01;
    localparam logic [1:0] ACK_NONE   = 2'b11;
endpackage

// File: rtl/bsb_tick_gen.sv
`timescale 1ns/1ps
module bsb_tick_gen
    import bsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ratio_sel,
    output logic       tick
);
    logic [1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= 2'd0;
        end else begin
            unique case (ratio_sel)
                RATIO_1X:  cnt <= 2'd0;
                RATIO_3_2: cnt <= (cnt >= 2'd2) ? 2'd0 : cnt + 2'd1;
                default:   cnt <= (cnt >= 2'd1) ? 2'd0 : cnt + 2'd1;
            endcase
        end
    end

    always_comb begin
        unique case (ratio_sel)
            RATIO_1X:  tick = 1'b1;
            RATIO_3_2: tick = (cnt != 2'd2);
            default:   tick = (cnt == 2'd0);
        endcase
    end
endmodule

// File: rtl/bsb_sync.sv
`timescale 1ns/1ps
module bsb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d_async;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/bsb_strobe_dec.sv
`timescale 1ns/1ps
module bsb_strobe_dec
    import bsb_pkg::*;
(
    input  logic       a0,
    input  logic [1:0] siz,
    output logic       upper_en,
    output logic       lower_en
);
    always_comb begin
        if (a0) begin
            upper_en = 1'b0;
            lower_en = 1'b1;
        end else if (siz == SIZ_BYTE) begin
            upper_en = 1'b1;
            lower_en = 1'b0;
        end else begin
            upper_en = 1'b1;
            lower_en = 1'b1;
        end
    end
endmodule

// File: rtl/bus_size_bridge.sv
`timescale 1ns/1ps
module bus_size_bridge
    import bsb_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ratio_sel,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_siz,
    input  logic          cpu_rd,
    output logic [1:0]    cpu_dsack_n,
    output logic          cpu_berr,
    output logic [AW-2:0] leg_addr,
    output logic          leg_as_n,
    output logic          leg_uds_n,
    output logic          leg_lds_n,
    output logic          leg_rw,
    input  logic          leg_dtack_n,
    input  logic          leg_berr_n
);
    localparam int NSYNC = 2;

    bsb_state_e    state, nxt;
    logic [AW-1:0] addr_q;
    logic [1:0]    siz_q;
    logic          rd_q;
    logic          leg_tick;
    logic [NSYNC-1:0] sync_q;
    logic          dtack_s_n, berr_s_n;
    logic          upper_en, lower_en;

    bsb_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .tick(leg_tick)
    );

    bsb_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({leg_berr_n, leg_dtack_n}), .q(sync_q)
    );
    assign dtack_s_n = sync_q[0];
    assign berr_s_n  = sync_q[1];

    bsb_strobe_dec u_dec (
        .a0(addr_q[0]), .siz(siz_q), .upper_en(upper_en), .lower_en(lower_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            siz_q  <= 2'b00;
            rd_q   <= 1'b1;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && cpu_req) begin
                addr_q <= cpu_addr;
                siz_q  <= cpu_siz;
                rd_q   <= cpu_rd;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (cpu_req) nxt = ST_STRETCH;
            ST_STRETCH: if (leg_tick) nxt = ST_ADDR;
            ST_ADDR:    if (leg_tick) nxt = ST_STRB;
            ST_STRB:    if (leg_tick) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!berr_s_n)                     nxt = ST_BERR;
                else if (leg_tick && !dtack_s_n)   nxt = ST_ACK;
            end
            ST_ACK:     if (!cpu_req) nxt = ST_IDLE;
            ST_BERR:    if (!cpu_req) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        leg_as_n    = 1'b1;
        leg_uds_n   = 1'b1;
        leg_lds_n   = 1'b1;
        leg_rw      = 1'b1;
        cpu_dsack_n = ACK_NONE;
        cpu_berr    = 1'b0;
        unique case (state)
            ST_ADDR: leg_rw = rd_q;
            ST_STRB: begin
                leg_rw   = rd_q;
                leg_as_n = 1'b0;
                if (rd_q) begin
                    leg_uds_n = ~upper_en;
                    leg_lds_n = ~lower_en;
                end
            end
            ST_WAIT: begin
                leg_rw    = rd_q;
                leg_as_n  = 1'b0;
                leg_uds_n = ~upper_en;
                leg_lds_n = ~lower_en;
            end
            ST_ACK:  cpu_dsack_n = ACK_PORT16;
            ST_BERR: cpu_berr    = 1'b1;
            default: ;
        endcase
    end

    assign leg_addr = addr_q[AW-1:1];
endmodule

// File: rtl/bsb_chk.sv
`timescale 1ns/1ps
module bsb_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    dsack_n,
    input logic          berr,
    input logic          as_n,
    input logic          uds_n,
    input logic          lds_n,
    input logic          dtack_n,
    input logic [AW-2:0] laddr
);
    logic [1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hi_cnt <= 2'd0;
        else if (!as_n)               hi_cnt <= 2'd0;
        else if (tick && hi_cnt != 2'd3) hi_cnt <= hi_cnt + 2'd1;
    end

    // R5
    dsack_port16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsack_n[0] == 1'b1);

    // R9
    berr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (dsack_n == 2'b11 && as_n));

    // R10
    ds_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uds_n || !lds_n) |-> !as_n);

    // R10
    as_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> hi_cnt != 2'd0);

    // R6
    dtack_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsack_n[1]) |-> !$past(dtack_n, 3));

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && $past(!as_n)) |-> $stable(laddr));
endmodule

bind bus_size_bridge bsb_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(leg_tick), .dsack_n(cpu_dsack_n),
    .berr(cpu_berr), .as_n(leg_as_n), .uds_n(leg_uds_n), .lds_n(leg_lds_n),
    .dtack_n(leg_dtack_n), .laddr(leg_addr)
);

// File: tb/sim_bus_size_bridge.sv
`timescale 1ns/1ps
module sim_bus_size_bridge;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ratio_sel = 2'd0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [1:0]    cpu_siz = 2'b10;
    logic          cpu_rd = 1'b1;
    logic [1:0]    cpu_dsack_n;
    logic          cpu_berr;
    logic [AW-2:0] leg_addr;
    logic          leg_as_n, leg_uds_n, leg_lds_n, leg_rw;
    logic          leg_dtack_n = 1'b1;
    logic          leg_berr_n = 1'b1;

    int n_cmp = 0, n_mis = 0, ncyc = 0;
    int mdly = 1, mcnt = 0;
    bit hold_hi = 0, early = 0, berr_mode = 0;
    bit as_prev = 1, ds_seen = 0;
    int leg_cycles = 0, as_at = 0, ds_at = 0, dt_at = 0, ack_at = 0;
    logic [AW-2:0] cap_addr;
    logic cap_rw, cap_u, cap_l;

    always #2 clk = ~clk;

    bus_size_bridge #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .cpu_req(cpu_req),
        .cpu_addr(cpu_addr), .cpu_siz(cpu_siz), .cpu_rd(cpu_rd),
        .cpu_dsack_n(cpu_dsack_n), .cpu_berr(cpu_berr), .leg_addr(leg_addr),
        .leg_as_n(leg_as_n), .leg_uds_n(leg_uds_n), .leg_lds_n(leg_lds_n),
        .leg_rw(leg_rw), .leg_dtack_n(leg_dtack_n), .leg_berr_n(leg_berr_n)
    );

    always @(posedge clk) ncyc++;

    // legacy memory model with programmable acknowledge delay
    always @(negedge clk) begin
        if (!leg_as_n && as_prev) begin
            leg_cycles++;
            cap_addr = leg_addr;
            cap_rw   = leg_rw;
            as_at    = ncyc;
            ds_seen  = 0;
        end
        if (!leg_as_n && !ds_seen && !(leg_uds_n && leg_lds_n)) begin
            ds_seen = 1;
            cap_u   = ~leg_uds_n;
            cap_l   = ~leg_lds_n;
            ds_at   = ncyc;
        end
        if (ds_seen && !leg_as_n) begin
            mcnt++;
            if (mcnt >= mdly && !hold_hi) begin
                if (berr_mode) leg_berr_n = 1'b0;
                else if (leg_dtack_n) begin
                    leg_dtack_n = 1'b0;
                    dt_at = ncyc;
                end
            end
        end else begin
            mcnt        = 0;
            leg_dtack_n = !early;
            leg_berr_n  = 1'b1;
        end
        as_prev = leg_as_n;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_ds(input logic a0, input logic [1:0] s);
        if (a0) return 2'b01;
        if (s == 2'b01) return 2'b10;
        return 2'b11;
    endfunction

    task automatic start_req(input logic [AW-1:0] a, input logic [1:0] s, input bit r);
        @(negedge clk);
        cpu_addr = a; cpu_siz = s; cpu_rd = r; cpu_req = 1'b1;
    endtask

    task automatic wait_ack(input int lim, inout int n_as, output int n_ack, input int base);
        n_ack = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (n_as < 0 && !leg_as_n) n_as = base + i;
            if (cpu_dsack_n != 2'b11 || cpu_berr) begin
                n_ack  = base + i;
                ack_at = ncyc;
                break;
            end
        end
    endtask

    task automatic end_cycle(input string rq);
        logic [1:0] d;
        logic b;
        d = cpu_dsack_n; b = cpu_berr;
        @(negedge clk);
        chk(cpu_dsack_n == d && cpu_berr == b, "R5 hold", int'(cpu_dsack_n), int'(d));
        cpu_req = 1'b0;
        @(negedge clk);
        chk(cpu_dsack_n == 2'b11 && !cpu_berr && leg_as_n, rq,
            int'({cpu_berr, cpu_dsack_n}), 3);
    endtask

    task automatic run(input logic [AW-1:0] a, input logic [1:0] s, input bit r,
                       output int n_as, output int n_ack);
        n_as = -1;
        start_req(a, s, r);
        wait_ack(400, n_as, n_ack, 0);
    endtask

    task automatic t_reset();
        chk(leg_as_n && leg_uds_n && leg_lds_n && leg_rw && cpu_dsack_n == 2'b11 && !cpu_berr,
            "R1 reset", int'({leg_as_n, leg_uds_n, leg_lds_n, leg_rw, cpu_dsack_n, cpu_berr}), 7'b1111110);
    endtask

    task automatic t_stretch();
        int na, nk;
        ratio_sel = 2'd0; mdly = 1;
        run(24'h001234, 2'b01, 1'b1, na, nk);
        chk(na == 3, "R2 stretch 1x", na, 3);
        chk(nk > 0 && cpu_dsack_n == 2'b01, "R5 dsack", int'(cpu_dsack_n), 1);
        chk({cap_u, cap_l} == 2'b10, "R3 byte even", int'({cap_u, cap_l}), 2);
        chk(cap_addr == 23'h00091A, "R11 addr", int'(cap_addr), 23'h00091A);
        chk(cap_rw == 1'b1 && ds_at == as_at, "R4 read", ds_at - as_at, 0);
        end_cycle("R5 release");
    endtask

    task automatic t_decode(input logic [AW-1:0] a, input logic [1:0] s);
        int na, nk;
        logic [1:0] e;
        e = exp_ds(a[0], s);
        run(a, s, 1'b1, na, nk);
        chk({cap_u, cap_l} == e, "R3 decode", int'({cap_u, cap_l}), int'(e));
        chk(cap_addr == a[AW-1:1], "R11 addr", int'(cap_addr), int'(a[AW-1:1]));
        end_cycle("R5 release");
    endtask

    task automatic t_write(input logic [1:0] ratio, input int lag);
        int na, nk;
        ratio_sel = ratio;
        run(24'h000400, 2'b10, 1'b0, na, nk);
        chk(cap_rw == 1'b0, "R4 write rw", int'(cap_rw), 0);
        chk(ds_at - as_at == lag, "R4 write lag", ds_at - as_at, lag);
        chk({cap_u, cap_l} == 2'b11, "R3 word", int'({cap_u, cap_l}), 3);
        end_cycle("R5 release");
    endtask

    task automatic t_long();
        int na, nk, c0;
        ratio_sel = 2'd0;
        c0 = leg_cycles;
        run(24'h000100, 2'b00, 1'b1, na, nk);
        chk(cpu_dsack_n == 2'b01, "R5 long first", int'(cpu_dsack_n), 1);
        end_cycle("R5 release");
        run(24'h000102, 2'b10, 1'b1, na, nk);
        chk(cap_addr == 23'h000081, "R11 second half", int'(cap_addr), 23'h81);
        end_cycle("R5 release");
        chk(leg_cycles - c0 == 2, "R5 two cycles", leg_cycles - c0, 2);
    endtask

    task automatic t_delay(input logic [1:0] ratio, input int d);
        int na, nk;
        ratio_sel = ratio; mdly = d;
        run(24'h002000, 2'b10, 1'b1, na, nk);
        chk(nk > 0 && ack_at - dt_at >= 3, "R6 sync delay", ack_at - dt_at, 3);
        end_cycle("R5 release");
        mdly = 1;
    endtask

    task automatic t_holdoff();
        int na, nk;
        ratio_sel = 2'd2; hold_hi = 1;
        na = -1;
        start_req(24'h003000, 2'b10, 1'b1);
        wait_ack(40, na, nk, 0);
        chk(nk < 0 && !leg_as_n, "R6 no ack while dtack high", nk, -1);
        hold_hi = 0;
        wait_ack(60, na, nk, 40);
        chk(nk > 0 && cpu_dsack_n == 2'b01, "R6 ack after release", int'(cpu_dsack_n), 1);
        end_cycle("R5 release");
    endtask

    task automatic t_early(input logic [1:0] ratio, input int exp_gap, input int lo, input int hi);
        int na, nk;
        ratio_sel = ratio; early = 1;
        repeat (2) @(negedge clk);
        run(24'h004000, 2'b10, 1'b1, na, nk);
        chk(nk - na == exp_gap, "R7 early dtack gap", nk - na, exp_gap);
        chk(na >= lo && na <= hi, "R8 strobe delay", na, lo);
        end_cycle("R5 release");
        early = 0;
    endtask

    task automatic t_berr();
        int na, nk;
        ratio_sel = 2'd0; berr_mode = 1; mdly = 2;
        run(24'h005000, 2'b10, 1'b1, na, nk);
        chk(cpu_berr && cpu_dsack_n == 2'b11 && leg_as_n && leg_uds_n && leg_lds_n,
            "R9 berr response", int'({cpu_berr, cpu_dsack_n, leg_as_n}), 4'b1111);
        end_cycle("R9 idle after berr");
        berr_mode = 0; mdly = 1;
        run(24'h005002, 2'b10, 1'b1, na, nk);
        chk(cpu_dsack_n == 2'b01, "R9 next cycle normal", int'(cpu_dsack_n), 1);
        end_cycle("R5 release");
    endtask

    initial begin
        #(4 * 150000);
        n_mis++;
        $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_stretch();
        ratio_sel = 2'd0;
        t_decode(24'h000011, 2'b01);
        t_decode(24'h000020, 2'b10);
        t_decode(24'h000031, 2'b10);
        t_decode(24'h000041, 2'b00);
        t_decode(24'h000050, 2'b11);
        t_write(2'd0, 1);
        t_write(2'd2, 2);
        t_long();
        t_delay(2'd0, 5);
        t_delay(2'd1, 4);
        t_delay(2'd2, 7);
        t_holdoff();
        t_early(2'd0, 2, 3, 3);
        t_early(2'd1, 3, 3, 5);
        t_early(2'd2, 4, 4, 5);
        t_early(2'd3, 4, 4, 5);
        t_berr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule